// File: doc/BRIEF.md
# Deep-Sleep Power-Down and Wake Sequencer

This block is a hardware state machine that puts a DRAM subsystem and its PLL into deep sleep, and later brings them back. It takes the place of a software routine. When it gets a sleep request, it walks through a fixed, interlocked chain of steps:

1. It moves the memory controller into low-power self-refresh.
2. It stops the memory clock.
3. It waits a fixed settling time.
4. It asks the module power controller to disable the memory module.
5. It gates the PHY clock divider.
6. It drops the PLL into bypass.
7. After a bypass dwell, it powers the PLL down.
8. Only then does it raise the system sleep-enable level.

A wake pulse while the block is asleep replays the chain in reverse. The PLL is reset, powered up, released from reset and given time to lock. The PLL, the divider and the module are then re-enabled, and the memory controller is taken out of its low-power state.

Every control output is a registered level. The dwell times are fixed counter waits, not polled ready flags. The three PLL waits are set in microseconds and scaled by the reference frequency in MHz. The module power controller is reached through a level request carrying a two-bit target state, which is held until an acknowledge arrives. A busy level covers each sequence, and a one-cycle done pulse marks the end of each one.

Top module: `dsleep_seq`

## Requirements
- R1: After reset:
  - `mem_srpd_sel_o`=1, `mem_lpm_en_o`=0, `mem_clk_stop_o`=0, `pmc_req_o`=0, `pmc_state_o`=2'b11, `phy_div_en_o`=1, `pll_en_o`=1, `pll_en_src_o`=1, `pll_pwrdn_o`=0, `pll_rst_n_o`=1, `sys_sleep_en_o`=0, `busy_o`=0, and both done pulses are 0.
- R2: A `sleep_req_i` sampled high while idle changes three outputs on one edge: `mem_srpd_sel_o` clears, `mem_lpm_en_o` sets and `busy_o` rises. `mem_clk_stop_o` sets exactly one cycle later.
- R3: Exactly PHY_WAIT_CYC cycles after the memory clock stops, `pmc_req_o` rises with `pmc_state_o`=2'b10 (disable). Request and code stay unchanged until `pmc_ack_i` is sampled high.
- R4: On the edge that samples the disable acknowledge, `pmc_req_o` falls and `phy_div_en_o` clears. One cycle later, `pll_en_o` and `pll_en_src_o` clear together (bypass).
- R5: `pll_pwrdn_o` sets exactly BYPASS_US*REF_MHZ cycles after bypass. One cycle after that, `sys_sleep_en_o` sets, `busy_o` falls and `sleep_done_o` pulses for one cycle.
- R6: Each wait lasts exactly its programmed count of cycles, and a count of 1 gives a one-cycle wait.
- R7: A `wake_i` sampled high while asleep clears `sys_sleep_en_o` and raises `busy_o`. The following steps come on successive cycles:
  - `pll_rst_n_o` falls one cycle later.
  - `pll_pwrdn_o` clears the cycle after that.
  - `pll_rst_n_o` rises exactly RESET_US*REF_MHZ cycles later.
- R8: Exactly LOCK_US*REF_MHZ cycles after reset release, `pll_en_o` sets while `pll_en_src_o` stays 0. `phy_div_en_o` sets one cycle later. `pmc_req_o` rises with `pmc_state_o`=2'b11 (enable) one cycle after that.
- R9: On the edge that samples the enable acknowledge, `pmc_req_o` falls and `mem_clk_stop_o` clears. One cycle later, `mem_lpm_en_o` clears, `busy_o` falls and `wake_done_o` pulses. The block is then idle again.
- R10: The following inputs change no output:
  - a `wake_i` pulse during the entry sequence;
  - a `sleep_req_i` during a sequence;
  - a `sleep_req_i` while asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req_i | input | 1 | Start the power-down sequence (sampled while idle) |
| wake_i | input | 1 | Start the wake sequence (sampled while asleep) |
| pmc_ack_i | input | 1 | Module power controller acknowledge |
| mem_srpd_sel_o | output | 1 | Memory controller self-refresh/power-down select |
| mem_lpm_en_o | output | 1 | Memory controller low-power-mode enable |
| mem_clk_stop_o | output | 1 | Memory clock stop enable |
| pmc_req_o | output | 1 | Module state change request |
| pmc_state_o | output | 2 | Requested module state (2'b10 disable, 2'b11 enable) |
| phy_div_en_o | output | 1 | PHY clock divider enable |
| pll_en_o | output | 1 | PLL enable (0 = bypass) |
| pll_en_src_o | output | 1 | PLL enable-source select |
| pll_pwrdn_o | output | 1 | PLL power-down |
| pll_rst_n_o | output | 1 | PLL reset, active low |
| sys_sleep_en_o | output | 1 | System deep-sleep enable |
| busy_o | output | 1 | A sequence is in progress |
| sleep_done_o | output | 1 | One-cycle pulse at the end of power-down |
| wake_done_o | output | 1 | One-cycle pulse at the end of wake |

## Verification
The hardest behaviour to reach from the ports is the set of ignored inputs:
- a wake that arrives in the middle of the entry chain;
- a sleep request that arrives while the block is already asleep.

Both must leave every output untouched. The bench drives a wake pulse and a second sleep request during the PHY dwell, and another sleep request after sleep-enable is reached. Its monitor treats any output change that the scoreboard did not queue as a failure.

The bench also varies how long the acknowledge is delayed, so the request-hold and release edges move relative to the rest of the chain. It sets the bypass dwell to one cycle to exercise the shortest wait.

// File: rtl/dsleep_pkg.sv
package dsleep_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_ENT_CLKSTOP,
    ST_ENT_PHYWAIT,
    ST_ENT_MODOFF,
    ST_ENT_BYPASS,
    ST_ENT_BYPWAIT,
    ST_ENT_SLEEP,
    ST_ASLEEP,
    ST_WK_RESET,
    ST_WK_PWRUP,
    ST_WK_RSTWAIT,
    ST_WK_LOCKWAIT,
    ST_WK_DIVON,
    ST_WK_MODREQ,
    ST_WK_MODON,
    ST_WK_LPMOFF
  } seq_state_e;

  typedef enum logic [1:0] {
    TW_PHY,
    TW_BYPASS,
    TW_RESET,
    TW_LOCK
  } wait_sel_e;

  localparam logic [1:0] MOD_DISABLE = 2'b10;
  localparam logic [1:0] MOD_ENABLE  = 2'b11;

endpackage

// File: rtl/dsleep_wait_timer.sv
module dsleep_wait_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // last cycle of the wait: the count is about to reach zero
  assign expire_o = (cnt_q == W'(1));

endmodule

// File: rtl/dsleep_pmc_hs.sv
module dsleep_pmc_hs (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] code_i,
  input  logic       ack_i,
  output logic       req_o,
  output logic [1:0] code_o,
  output logic       done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      code_o <= dsleep_pkg::MOD_ENABLE;
    end else if (start_i) begin
      req_o  <= 1'b1;
      code_o <= code_i;
    end else if (req_o && ack_i) begin
      req_o  <= 1'b0;
    end
  end

  assign done_o = req_o & ack_i;

endmodule

// File: rtl/dsleep_seq.sv
module dsleep_seq #(
  parameter int REF_MHZ      = 25,
  parameter int PHY_WAIT_CYC = 4096,
  parameter int BYPASS_US    = 4,
  parameter int RESET_US     = 5,
  parameter int LOCK_US      = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req_i,
  input  logic       wake_i,
  input  logic       pmc_ack_i,
  output logic       mem_srpd_sel_o,
  output logic       mem_lpm_en_o,
  output logic       mem_clk_stop_o,
  output logic       pmc_req_o,
  output logic [1:0] pmc_state_o,
  output logic       phy_div_en_o,
  output logic       pll_en_o,
  output logic       pll_en_src_o,
  output logic       pll_pwrdn_o,
  output logic       pll_rst_n_o,
  output logic       sys_sleep_en_o,
  output logic       busy_o,
  output logic       sleep_done_o,
  output logic       wake_done_o
);
  import dsleep_pkg::*;

  localparam int BYP_CYC  = BYPASS_US * REF_MHZ;
  localparam int RST_CYC  = RESET_US * REF_MHZ;
  localparam int LOCK_CYC = LOCK_US * REF_MHZ;
  localparam int MAX_AB   = (PHY_WAIT_CYC > BYP_CYC) ? PHY_WAIT_CYC : BYP_CYC;
  localparam int MAX_CD   = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC;
  localparam int MAX_CYC  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  seq_state_e   state_q;
  wait_sel_e    tmr_sel;
  logic         tmr_load;
  logic         tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic         hs_start;
  logic [1:0]   hs_code;
  logic         hs_done;

  always_comb begin
    case (tmr_sel)
      TW_PHY:    tmr_val = CNT_W'(PHY_WAIT_CYC);
      TW_BYPASS: tmr_val = CNT_W'(BYP_CYC);
      TW_RESET:  tmr_val = CNT_W'(RST_CYC);
      default:   tmr_val = CNT_W'(LOCK_CYC);
    endcase
  end

  dsleep_wait_timer #(.W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (tmr_exp)
  );

  dsleep_pmc_hs u_pmc (
    .clk     (clk),
    .rst     (rst),
    .start_i (hs_start),
    .code_i  (hs_code),
    .ack_i   (pmc_ack_i),
    .req_o   (pmc_req_o),
    .code_o  (pmc_state_o),
    .done_o  (hs_done)
  );

  // timer loads and handshake starts decoded from the current state
  always_comb begin
    tmr_load = 1'b0;
    tmr_sel  = TW_PHY;
    hs_start = 1'b0;
    hs_code  = MOD_ENABLE;
    case (state_q)
      ST_ENT_CLKSTOP: begin
        tmr_load = 1'b1;
        tmr_sel  = TW_PHY;
      end
      ST_ENT_PHYWAIT: begin
        hs_start = tmr_exp;
        hs_code  = MOD_DISABLE;
      end
      ST_ENT_BYPASS: begin
        tmr_load = 1'b1;
        tmr_sel  = TW_BYPASS;
      end
      ST_WK_PWRUP: begin
        tmr_load = 1'b1;
        tmr_sel  = TW_RESET;
      end
      ST_WK_RSTWAIT: begin
        tmr_load = tmr_exp;
        tmr_sel  = TW_LOCK;
      end
      ST_WK_MODREQ: begin
        hs_start = 1'b1;
        hs_code  = MOD_ENABLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      mem_srpd_sel_o <= 1'b1;
      mem_lpm_en_o   <= 1'b0;
      mem_clk_stop_o <= 1'b0;
      phy_div_en_o   <= 1'b1;
      pll_en_o       <= 1'b1;
      pll_en_src_o   <= 1'b1;
      pll_pwrdn_o    <= 1'b0;
      pll_rst_n_o    <= 1'b1;
      sys_sleep_en_o <= 1'b0;
      busy_o         <= 1'b0;
      sleep_done_o   <= 1'b0;
      wake_done_o    <= 1'b0;
    end else begin
      sleep_done_o <= 1'b0;
      wake_done_o  <= 1'b0;
      case (state_q)
        ST_IDLE: if (sleep_req_i) begin
          mem_srpd_sel_o <= 1'b0;
          mem_lpm_en_o   <= 1'b1;
          busy_o         <= 1'b1;
          state_q        <= ST_ENT_CLKSTOP;
        end
        ST_ENT_CLKSTOP: begin
          mem_clk_stop_o <= 1'b1;
          state_q        <= ST_ENT_PHYWAIT;
        end
        ST_ENT_PHYWAIT: if (tmr_exp) state_q <= ST_ENT_MODOFF;
        ST_ENT_MODOFF: if (hs_done) begin
          phy_div_en_o <= 1'b0;
          state_q      <= ST_ENT_BYPASS;
        end
        ST_ENT_BYPASS: begin
          pll_en_o     <= 1'b0;
          pll_en_src_o <= 1'b0;
          state_q      <= ST_ENT_BYPWAIT;
        end
        ST_ENT_BYPWAIT: if (tmr_exp) begin
          pll_pwrdn_o <= 1'b1;
          state_q     <= ST_ENT_SLEEP;
        end
        ST_ENT_SLEEP: begin
          sys_sleep_en_o <= 1'b1;
          busy_o         <= 1'b0;
          sleep_done_o   <= 1'b1;
          state_q        <= ST_ASLEEP;
        end
        ST_ASLEEP: if (wake_i) begin
          sys_sleep_en_o <= 1'b0;
          busy_o         <= 1'b1;
          state_q        <= ST_WK_RESET;
        end
        ST_WK_RESET: begin
          pll_rst_n_o <= 1'b0;
          state_q     <= ST_WK_PWRUP;
        end
        ST_WK_PWRUP: begin
          pll_pwrdn_o <= 1'b0;
          state_q     <= ST_WK_RSTWAIT;
        end
        ST_WK_RSTWAIT: if (tmr_exp) begin
          pll_rst_n_o <= 1'b1;
          state_q     <= ST_WK_LOCKWAIT;
        end
        ST_WK_LOCKWAIT: if (tmr_exp) begin
          pll_en_o     <= 1'b1;
          pll_en_src_o <= 1'b0;
          state_q      <= ST_WK_DIVON;
        end
        ST_WK_DIVON: begin
          phy_div_en_o <= 1'b1;
          state_q      <= ST_WK_MODREQ;
        end
        ST_WK_MODREQ: state_q <= ST_WK_MODON;
        ST_WK_MODON: if (hs_done) begin
          mem_clk_stop_o <= 1'b0;
          state_q        <= ST_WK_LPMOFF;
        end
        ST_WK_LPMOFF: begin
          mem_lpm_en_o <= 1'b0;
          busy_o       <= 1'b0;
          wake_done_o  <= 1'b1;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dsleep_seq_chk.sv
module dsleep_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pmc_ack_i,
  input logic       mem_lpm_en_o,
  input logic       mem_clk_stop_o,
  input logic       pmc_req_o,
  input logic [1:0] pmc_state_o,
  input logic       phy_div_en_o,
  input logic       pll_en_o,
  input logic       pll_pwrdn_o,
  input logic       pll_rst_n_o,
  input logic       sys_sleep_en_o,
  input logic       busy_o,
  input logic       sleep_done_o,
  input logic       wake_done_o
);

  // R2: clock stop only after low-power mode was already on
  p_clkstop_after_lpm_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_clk_stop_o) |-> mem_lpm_en_o && $past(mem_lpm_en_o));

  // R3: request and its code hold until acknowledged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (pmc_req_o && !pmc_ack_i) |=> (pmc_req_o && $stable(pmc_state_o)));

  // R4: divider is never running while the PLL is bypassed
  p_div_off_in_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    !pll_en_o |-> !phy_div_en_o);

  // R5: sleep-enable rises only with the PLL powered down and bypassed
  p_sleep_after_pwrdn_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_sleep_en_o) |-> (pll_pwrdn_o && !pll_en_o && $past(pll_pwrdn_o)));

  // R5, R9: completion pulses are exclusive and end the busy phase
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (sleep_done_o || wake_done_o) |-> (!busy_o && $onehot0({sleep_done_o, wake_done_o})));

  // R7: power-down is lifted only while the PLL is held in reset
  p_pwrup_in_reset_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_pwrdn_o) |-> (!pll_rst_n_o && !sys_sleep_en_o));

  // R9: low-power mode is left only after the memory clock restarted
  p_lpm_after_clk_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_lpm_en_o) |-> (!mem_clk_stop_o && $past(!mem_clk_stop_o)));

endmodule

bind dsleep_seq dsleep_seq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .pmc_ack_i      (pmc_ack_i),
  .mem_lpm_en_o   (mem_lpm_en_o),
  .mem_clk_stop_o (mem_clk_stop_o),
  .pmc_req_o      (pmc_req_o),
  .pmc_state_o    (pmc_state_o),
  .phy_div_en_o   (phy_div_en_o),
  .pll_en_o       (pll_en_o),
  .pll_pwrdn_o    (pll_pwrdn_o),
  .pll_rst_n_o    (pll_rst_n_o),
  .sys_sleep_en_o (sys_sleep_en_o),
  .busy_o         (busy_o),
  .sleep_done_o   (sleep_done_o),
  .wake_done_o    (wake_done_o)
);

// File: tb/tb_dsleep_seq.sv
module tb_dsleep_seq;

  localparam int REF   = 1;
  localparam int PHYW  = 5;
  localparam int BYPW  = 1 * REF;
  localparam int RSTW  = 3 * REF;
  localparam int LOCKW = 6 * REF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic wake = 1'b0;
  logic ack = 1'b0;
  logic srpd, lpm, mclk, req, div, plen, plsrc, pwrdn, prstn, slp, busy, sdone, wdone;
  logic [1:0] code;

  always #4 clk = ~clk;

  dsleep_seq #(
    .REF_MHZ(REF), .PHY_WAIT_CYC(PHYW), .BYPASS_US(1), .RESET_US(3), .LOCK_US(6)
  ) dut (
    .clk(clk), .rst(rst), .sleep_req_i(sleep_req), .wake_i(wake), .pmc_ack_i(ack),
    .mem_srpd_sel_o(srpd), .mem_lpm_en_o(lpm), .mem_clk_stop_o(mclk),
    .pmc_req_o(req), .pmc_state_o(code), .phy_div_en_o(div), .pll_en_o(plen),
    .pll_en_src_o(plsrc), .pll_pwrdn_o(pwrdn), .pll_rst_n_o(prstn),
    .sys_sleep_en_o(slp), .busy_o(busy), .sleep_done_o(sdone), .wake_done_o(wdone)
  );

  typedef struct {
    logic [12:0] vec;
    int          gap;
    logic        sd;
    logic        wd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int ack_dly = 0;
  int ack_cnt = 0;
  bit mon_en = 0;

  // model of the expected outputs
  logic m_srpd = 1, m_lpm = 0, m_mclk = 0, m_req = 0, m_div = 1, m_plen = 1;
  logic m_plsrc = 1, m_pwrdn = 0, m_prstn = 1, m_slp = 0, m_busy = 0;
  logic [1:0] m_code = 2'b11;

  function automatic logic [12:0] obs();
    return {srpd, lpm, mclk, req, code, div, plen, plsrc, pwrdn, prstn, slp, busy};
  endfunction

  function automatic logic [12:0] model();
    return {m_srpd, m_lpm, m_mclk, m_req, m_code, m_div, m_plen, m_plsrc,
            m_pwrdn, m_prstn, m_slp, m_busy};
  endfunction

  task automatic push(input string tag, input int gap, input logic sd, input logic wd);
    exp_t e;
    e.vec = model(); e.gap = gap; e.sd = sd; e.wd = wd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // acknowledge responder for the module power controller
  always @(negedge clk) begin
    if (rst) begin
      ack = 1'b0; ack_cnt = 0;
    end else if (req && !ack) begin
      if (ack_cnt == ack_dly) ack = 1'b1;
      else ack_cnt++;
    end else if (!req) begin
      ack = 1'b0; ack_cnt = 0;
    end
  end

  // monitor: every output change must match the next queued item
  logic [12:0] prev;
  int gap_cnt = 0;
  always @(negedge clk) begin
    if (!rst && mon_en) begin
      logic [12:0] cur;
      cur = obs();
      gap_cnt++;
      if (cur != prev) begin
        if (q.size() == 0) begin
          check("R10 unexpected change", 1'b0, cur, prev);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " vector"}, cur == e.vec, cur, e.vec);
          if (e.gap >= 0) check({e.tag, " cycles"}, gap_cnt == e.gap, gap_cnt, e.gap);
          check({e.tag, " done pulses"}, {sdone, wdone} == {e.sd, e.wd},
                {sdone, wdone}, {e.sd, e.wd});
        end
        gap_cnt = 0;
        prev = cur;
      end else if (sdone || wdone) begin
        check("R5/R9 stray done pulse", 1'b0, {sdone, wdone}, 0);
      end
    end
  end

  task automatic pulse_sleep();
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; @(negedge clk); wake = 1'b0;
  endtask

  task automatic expect_sleep(input int ad);
    m_srpd = 0; m_lpm = 1; m_busy = 1;      push("R2 lpm entry", -1, 0, 0);
    m_mclk = 1;                              push("R2 clock stop", 1, 0, 0);
    m_req = 1; m_code = 2'b10;               push("R3 disable request", PHYW, 0, 0);
    m_req = 0; m_div = 0;                    push("R4 divider off", ad + 1, 0, 0);
    m_plen = 0; m_plsrc = 0;                 push("R4 bypass", 1, 0, 0);
    m_pwrdn = 1;                             push("R6 one-cycle bypass wait", BYPW, 0, 0);
    m_slp = 1; m_busy = 0;                   push("R5 sleep enable", 1, 1, 0);
  endtask

  task automatic expect_wake(input int ad);
    m_slp = 0; m_busy = 1;                   push("R7 sleep clear", -1, 0, 0);
    m_prstn = 0;                             push("R7 pll reset", 1, 0, 0);
    m_pwrdn = 0;                             push("R7 power up", 1, 0, 0);
    m_prstn = 1;                             push("R7 reset wait", RSTW, 0, 0);
    m_plen = 1;                              push("R8 lock wait", LOCKW, 0, 0);
    m_div = 1;                               push("R8 divider on", 1, 0, 0);
    m_req = 1; m_code = 2'b11;               push("R8 enable request", 1, 0, 0);
    m_req = 0; m_mclk = 0;                   push("R9 clock restart", ad + 1, 0, 0);
    m_lpm = 0; m_busy = 0;                   push("R9 lpm exit", 1, 0, 1);
  endtask

  task automatic wait_drained();
    while (q.size() != 0) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", obs() == model(), obs(), model());
    check("R1 reset pulses", {sdone, wdone} == 2'b00, {sdone, wdone}, 0);
    prev = obs();
    mon_en = 1;

    // round 1: zero-delay ack, wake and sleep requests during entry (R10)
    ack_dly = 0;
    expect_sleep(0);
    pulse_sleep();
    @(negedge clk);
    pulse_wake();
    pulse_sleep();
    wait_drained();
    repeat (4) @(negedge clk);
    pulse_sleep();
    repeat (6) @(negedge clk);
    check("R10 still asleep", slp == 1'b1 && busy == 1'b0, {slp, busy}, 2'b10);
    expect_wake(0);
    pulse_wake();
    pulse_sleep();
    wait_drained();
    repeat (4) @(negedge clk);

    // round 2: slow acknowledge stretches request hold (R3, R9)
    ack_dly = 3;
    expect_sleep(3);
    pulse_sleep();
    wait_drained();
    repeat (3) @(negedge clk);
    expect_wake(3);
    pulse_wake();
    wait_drained();
    repeat (5) @(negedge clk);
    check("R9 idle after wake", busy == 1'b0 && obs() == model(), obs(), model());

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule